// File: doc/BRIEF.md
# SPI Memory Status Register Front End

This block is the command decoder and status keeper of a serial-memory slave on an SPI bus. Chip select, serial clock and serial input are oversampled in the system clock domain. The block decodes an 8-bit instruction at the start of each selected frame. It answers a status read by shifting the status byte out on the serial output, which it drives through a separate output enable. It also accepts status writes and commands that set or clear the write-permit latch.

The status byte has a fixed layout. Bit 7 is a protect-enable flag and bits 3 and 2 are two block-protect flags; these three are writable and survive a reset of the interface logic. Bit 1 is the write-permit latch and bit 0 is the busy flag; both are read-only through the status-write path. Bits 6 to 4 always read 0.

An accepted status write starts an internal write cycle, modelled by a countdown of `WRITE_TICKS` system clocks. Throughout that countdown the busy flag reads 1. Status reads and latch commands remain usable while the countdown runs, so busy-time behaviour can be exercised without a memory array.

Top module: `spi_status_frontend`

## Requirements
- R1: After reset the output enable is 0 and the busy and write-permit flags are 0; before any status write has been accepted, a status read returns 0x00.
- R2: While the 8 instruction bits are clocked in after chip select falls, the output enable stays 0 (output high-impedance).
- R3: Instruction 0x05 (sent MSB first, sampled on rising SCK) returns the status byte MSB first on the next 8 clocks, updated on falling SCK. The layout is: bit 7 protect-enable, bits 6..4 zero, bit 3 block-protect high, bit 2 block-protect low, bit 1 write-permit latch, bit 0 busy.
- R4: Instruction 0x06 sets the write-permit latch and 0x04 clears it. Either takes effect only when chip select rises after exactly 8 clocks; a frame of any other length leaves the latch unchanged.
- R5: Instruction 0x01 followed by a data byte is accepted when the latch is 1, busy is 0, and chip select rises after exactly 16 clocks. It loads status bits 7, 3 and 2 from the same positions of the data byte; the other data bits are ignored.
- R6: A status write issued with the latch at 0, while busy, or with a clock count other than 16 leaves the status byte unchanged.
- R7: An accepted status write holds busy at 1 for `WRITE_TICKS` system clocks. Busy then returns to 0 and the latch clears.
- R8: While busy, a status read returns the live busy and latch values, and the set and clear latch commands still take effect.
- R9: A rising chip select at any point ends the frame: the output enable returns to 0, and the next frame counts its bits from zero.
- R10: Bits 7, 3 and 2 keep their values across a reset, while the latch and busy flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset of the interface logic |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, mode 0 |
| spi_si | input | 1 | Serial data in, sampled on rising SCK |
| spi_so | output | 1 | Serial data out, valid when enabled |
| spi_so_oe | output | 1 | Output enable of the serial data out driver |

## Verification
The embedded properties assume that SCK idles low when chip select falls. They also assume that each SCK level and each chip-select level lasts longer than the synchronizer plus edge-detect latency, so every pin edge is seen exactly once and in order. The stimulus drives all pins at falling system-clock edges and holds each SCK phase for eight system clocks. Chip select changes only while SCK is low, with at least one full phase of margin on both sides. Frames of the wrong length, and frames aborted in the instruction or data phase, are produced by stopping the clock early or adding one extra clock. They are never produced by glitching a pin.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;

    localparam logic [7:0] OP_WRITE_STATUS = 8'h01;
    localparam logic [7:0] OP_LATCH_CLEAR  = 8'h04;
    localparam logic [7:0] OP_READ_STATUS  = 8'h05;
    localparam logic [7:0] OP_LATCH_SET    = 8'h06;

    localparam int BYTE_BITS = 8;

    typedef enum logic [1:0] {
        CMD_NONE      = 2'd0,
        CMD_SET_LATCH = 2'd1,
        CMD_CLR_LATCH = 2'd2,
        CMD_WR_STATUS = 2'd3
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [7:0] data;
    } cmd_t;

    typedef struct packed {
        logic prot_en;
        logic blk_hi;
        logic blk_lo;
    } keep_bits_t;

    function automatic logic [7:0] build_status(input keep_bits_t kb,
                                                input logic latch,
                                                input logic busy);
        return {kb.prot_en, 3'b000, kb.blk_hi, kb.blk_lo, latch, busy};
    endfunction

    function automatic keep_bits_t keep_from_byte(input logic [7:0] d);
        keep_bits_t kb;
        kb.prot_en = d[7];
        kb.blk_hi  = d[3];
        kb.blk_lo  = d[2];
        return kb;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RESET_VAL;
                else     stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= RESET_VAL;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
    import spi_stat_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_s,
    input  logic       cs_n_s,
    input  logic       si_s,
    input  logic [7:0] status_byte,
    output logic       so,
    output logic       so_oe,
    output logic       cmd_valid,
    output cmd_t       cmd
);

    localparam int IDX_W = $clog2(BYTE_BITS);

    logic             sck_d, cs_n_d;
    logic [IDX_W-1:0] bit_idx;
    logic [1:0]       byte_cnt;
    logic [7:0]       shift_q, opcode_q, data_q, tx_q;
    logic             rd_mode, so_q, oe_q;

    logic       sck_rise, sck_fall, cs_rise, at_one_byte, at_two_bytes, last_bit;
    logic [7:0] shift_nxt;

    always_comb begin
        sck_rise     = sck_s & ~sck_d & ~cs_n_s;
        sck_fall     = ~sck_s & sck_d & ~cs_n_s;
        cs_rise      = cs_n_s & ~cs_n_d;
        shift_nxt    = {shift_q[6:0], si_s};
        last_bit     = (bit_idx == IDX_W'(BYTE_BITS - 1));
        at_one_byte  = (byte_cnt == 2'd1) && (bit_idx == '0);
        at_two_bytes = (byte_cnt == 2'd2) && (bit_idx == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d    <= 1'b0;
            cs_n_d   <= 1'b1;
            bit_idx  <= '0;
            byte_cnt <= '0;
            shift_q  <= '0;
            opcode_q <= '0;
            data_q   <= '0;
            tx_q     <= '0;
            rd_mode  <= 1'b0;
            so_q     <= 1'b0;
            oe_q     <= 1'b0;
        end else begin
            sck_d  <= sck_s;
            cs_n_d <= cs_n_s;
            if (cs_n_s) begin
                bit_idx  <= '0;
                byte_cnt <= '0;
                rd_mode  <= 1'b0;
                oe_q     <= 1'b0;
                so_q     <= 1'b0;
            end else begin
                if (sck_rise) begin
                    shift_q <= shift_nxt;
                    bit_idx <= bit_idx + IDX_W'(1);
                    if (last_bit) begin
                        if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
                        if (byte_cnt == 2'd0) begin
                            opcode_q <= shift_nxt;
                            rd_mode  <= (shift_nxt == OP_READ_STATUS);
                        end
                        if (byte_cnt == 2'd1) data_q <= shift_nxt;
                    end
                end
                if (sck_fall && rd_mode) begin
                    oe_q <= 1'b1;
                    if (bit_idx == '0) begin
                        so_q <= status_byte[7];
                        tx_q <= {status_byte[6:0], 1'b0};
                    end else begin
                        so_q <= tx_q[7];
                        tx_q <= {tx_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    always_comb begin
        cmd_valid = 1'b0;
        cmd.kind  = CMD_NONE;
        cmd.data  = data_q;
        if (cs_rise) begin
            if (at_one_byte && opcode_q == OP_LATCH_SET) begin
                cmd_valid = 1'b1;
                cmd.kind  = CMD_SET_LATCH;
            end else if (at_one_byte && opcode_q == OP_LATCH_CLEAR) begin
                cmd_valid = 1'b1;
                cmd.kind  = CMD_CLR_LATCH;
            end else if (at_two_bytes && opcode_q == OP_WRITE_STATUS) begin
                cmd_valid = 1'b1;
                cmd.kind  = CMD_WR_STATUS;
            end
        end
    end

    assign so    = so_q;
    assign so_oe = oe_q;

    AST_SO_QUIET_IN_OPCODE: assert property (@(posedge clk) disable iff (rst)
        (byte_cnt == 2'd0) |-> !oe_q); // R2
    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !oe_q); // R9
    AST_DESELECT_RESTART: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (bit_idx == '0 && byte_cnt == 2'd0)); // R9

endmodule

// File: rtl/spi_status_core.sv
module spi_status_core
    import spi_stat_pkg::*;
#(
    parameter int WRITE_TICKS = 5000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  cmd_t       cmd,
    output logic [7:0] status_byte
);

    localparam int CNT_W = $clog2(WRITE_TICKS + 1);

    keep_bits_t       keep_q = '0;
    logic             latch_q, busy_q;
    logic [CNT_W-1:0] count_q;
    logic             write_ok;

    always_comb begin
        write_ok = !rst && cmd_valid && (cmd.kind == CMD_WR_STATUS)
                   && latch_q && !busy_q;
    end

    always_ff @(posedge clk) begin
        if (write_ok) keep_q <= keep_from_byte(cmd.data);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= 1'b0;
            busy_q  <= 1'b0;
            count_q <= '0;
        end else begin
            if (busy_q) begin
                count_q <= count_q - CNT_W'(1);
                if (count_q == CNT_W'(1)) begin
                    busy_q  <= 1'b0;
                    latch_q <= 1'b0;
                end
            end
            if (cmd_valid) begin
                case (cmd.kind)
                    CMD_SET_LATCH: latch_q <= 1'b1;
                    CMD_CLR_LATCH: latch_q <= 1'b0;
                    CMD_WR_STATUS: if (write_ok) begin
                        busy_q  <= 1'b1;
                        count_q <= CNT_W'(WRITE_TICKS);
                    end
                    default: ;
                endcase
            end
        end
    end

    assign status_byte = build_status(keep_q, latch_q, busy_q);

    AST_BUSY_HAS_COUNT: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (count_q != '0)); // R7
    AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> $past(latch_q)); // R5
    AST_KEEP_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        !$stable(keep_q) |-> $rose(busy_q)); // R6
    AST_LATCH_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        ($fell(latch_q) && !$past(rst)) |->
            ($fell(busy_q) || $past(cmd_valid && cmd.kind == CMD_CLR_LATCH))); // R4

endmodule

// File: rtl/spi_status_frontend.sv
module spi_status_frontend
    import spi_stat_pkg::*;
#(
    parameter int WRITE_TICKS = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_si,
    output logic spi_so,
    output logic spi_so_oe
);

    logic [2:0] pins_s;
    logic [7:0] status_byte;
    logic       cmd_valid;
    cmd_t       cmd;

    spi_pin_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk(clk),
        .rst(rst),
        .d  ({spi_cs_n, spi_sck, spi_si}),
        .q  (pins_s)
    );

    spi_frame_ctrl u_frame (
        .clk        (clk),
        .rst        (rst),
        .sck_s      (pins_s[1]),
        .cs_n_s     (pins_s[2]),
        .si_s       (pins_s[0]),
        .status_byte(status_byte),
        .so         (spi_so),
        .so_oe      (spi_so_oe),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd)
    );

    spi_status_core #(
        .WRITE_TICKS(WRITE_TICKS)
    ) u_core (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd        (cmd),
        .status_byte(status_byte)
    );

endmodule

// File: tb/spi_status_frontend_test.sv
module spi_status_frontend_test;

    localparam int TICKS = 1500;
    localparam int HALF  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
    logic so, so_oe;
    int   n_checks = 0, n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    spi_status_frontend #(.WRITE_TICKS(TICKS), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst(rst), .spi_cs_n(cs_n), .spi_sck(sck),
        .spi_si(si), .spi_so(so), .spi_so_oe(so_oe)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_frame(input int nbits, input logic [31:0] tx,
                            output logic [31:0] rx, output logic [31:0] oe_bits);
        rx = '0;
        oe_bits = '0;
        @(negedge clk);
        cs_n = 1'b0;
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            si = tx[nbits-1-i];
            sck = 1'b0;
            repeat (HALF) @(negedge clk);
            rx[nbits-1-i] = so;
            oe_bits[nbits-1-i] = so_oe;
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sck = 1'b0;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        si = 1'b0;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic read_status(output logic [7:0] st, output logic [15:0] oe_pat);
        logic [31:0] rx, oe;
        do_frame(16, {16'h0, 8'h05, 8'h00}, rx, oe);
        st = rx[7:0];
        oe_pat = oe[15:0];
    endtask

    task automatic send_cmd(input logic [7:0] op);
        logic [31:0] rx, oe;
        do_frame(8, {24'h0, op}, rx, oe);
    endtask

    task automatic write_status(input logic [7:0] d);
        logic [31:0] rx, oe;
        do_frame(16, {16'h0, 8'h01, d}, rx, oe);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  st, d, keep;
        logic [15:0] oep;
        logic [31:0] rx, oe;

        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        check({31'h0, so_oe}, 32'h0, "R1 oe after reset");
        read_status(st, oep);
        check({24'h0, st}, 32'h00, "R1 R3 initial status");
        check({16'h0, oep[15:8]}, 32'h0, "R2 oe during instruction");
        check({16'h0, oep[7:0]}, 32'hFF, "R3 oe during data");

        send_cmd(8'h06);
        read_status(st, oep);
        check({24'h0, st}, 32'h02, "R4 latch set");
        send_cmd(8'h04);
        read_status(st, oep);
        check({24'h0, st}, 32'h00, "R4 latch clear");
        do_frame(9, {23'h0, 8'h06, 1'b0}, rx, oe);
        read_status(st, oep);
        check({24'h0, st}, 32'h00, "R4 set with 9 clocks ignored");

        write_status(8'h8C);
        read_status(st, oep);
        check({24'h0, st}, 32'h00, "R6 write without latch");

        keep = 8'h00;
        for (int i = 0; i < 32; i++) begin
            d = 8'(i * 37 + 3);
            send_cmd(8'h06);
            write_status(d);
            read_status(st, oep);
            check({24'h0, st}, {24'h0, (d & 8'h8C) | 8'h03}, "R5 R8 busy read after write");
            repeat (TICKS + 20) @(negedge clk);
            read_status(st, oep);
            keep = d & 8'h8C;
            check({24'h0, st}, {24'h0, keep}, "R5 R7 status after write cycle");
        end

        send_cmd(8'h06);
        write_status(8'hF7);
        keep = 8'h84;
        send_cmd(8'h04);
        read_status(st, oep);
        check({24'h0, st}, {24'h0, keep | 8'h01}, "R8 clear latch while busy");
        send_cmd(8'h06);
        read_status(st, oep);
        check({24'h0, st}, {24'h0, keep | 8'h03}, "R8 set latch while busy");
        write_status(8'h08);
        repeat (TICKS + 20) @(negedge clk);
        read_status(st, oep);
        check({24'h0, st}, {24'h0, keep}, "R6 R7 write while busy rejected");

        send_cmd(8'h06);
        do_frame(15, {17'h0, 8'h01, 7'h04}, rx, oe);
        read_status(st, oep);
        check({24'h0, st}, {24'h0, keep | 8'h02}, "R6 write with 15 clocks");
        do_frame(17, {15'h0, 8'h01, 8'h08, 1'b0}, rx, oe);
        read_status(st, oep);
        check({24'h0, st}, {24'h0, keep | 8'h02}, "R6 write with 17 clocks");

        do_frame(12, {20'h0, 8'h05, 4'h0}, rx, oe);
        check({28'h0, oe[3:0]}, 32'hF, "R9 oe on before abort");
        check({31'h0, so_oe}, 32'h0, "R9 oe off after abort");
        do_frame(5, 32'h0, rx, oe);
        send_cmd(8'h04);
        read_status(st, oep);
        check({24'h0, st}, {24'h0, keep}, "R9 count restarts after abort");

        send_cmd(8'h06);
        pulse_reset();
        check({31'h0, so_oe}, 32'h0, "R1 oe after second reset");
        read_status(st, oep);
        check({24'h0, st}, {24'h0, keep}, "R10 keep bits survive reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule